// File: doc/BRIEF.md
# Banked Internal Data Memory Decoder

This block holds the 256-byte internal data RAM of a small 8-bit microcontroller core. It also turns every data-memory operand into either a RAM byte or a request to the special function register (SFR) space. The core gives it one access per cycle in one of four modes: a working-register operand, a direct byte address, an indirect access through a pointer register, or a single-bit address. The core also supplies the two bank-select bits of its status word. Reads are combinational and return in the same cycle. Writes take effect at the next rising clock edge.

Working registers are taken from a bank chosen by the bank-select bits, so a change of bank applies to the very next access. In the upper half of the address space, the addressing mode decides the target. A direct address reaches the SFR space through a strobe and a read bus from outside. An indirect address reaches a second, hidden 128 bytes of RAM. Bit operands in the lower half act on a 16-byte flag region. The block merges a bit write into its containing byte within the one access. It also flags a zero result on the byte it returns, because the core has no zero flag of its own.

Top module: `iram_bank_decoder`

## Requirements
- R1: In register mode (`acc_mode`=2'b00), the RAM byte used is at address {3'b000, `bank_sel`[1:0], `reg_sel`[2:0]}.
- R2: A new `bank_sel` value applies to the register access in the same cycle, with no cycle of delay.
- R3: Direct mode (2'b01) and indirect mode (2'b10) with an address below 0x80 reach the same RAM byte.
- R4: Indirect mode with a pointer value of 0x80 or above reaches RAM bytes 0x80–0xFF and never asserts `sfr_stb`.
- R5: Direct mode with `addr`[7]=1 asserts `sfr_stb` and puts `addr` on `sfr_addr`. `rdata` then returns `sfr_rdata`. A write in this case sets `sfr_we` and `sfr_wdata`=`wdata` and leaves RAM unchanged.
- R6: The indirect pointer is the RAM byte at {3'b000, `bank_sel`, 2'b00, `ptr_sel`}, that is, register 0 or register 1 of the current bank.
- R7: In bit mode (2'b11), a bit address b below 0x80 selects bit b[2:0] of RAM byte 0x20+b[6:3], which is returned on `rbit`. A bit write changes only that bit of the byte.
- R8: In bit mode, a bit address b of 0x80 or above asserts `sfr_stb` with `sfr_addr`={b[7:3],3'b000}. `rbit` is then `sfr_rdata`[b[2:0]]. On a write, `sfr_wdata` is `sfr_rdata` with that bit replaced by `wbit`.
- R9: `rd_zero` is 1 exactly when `rdata` is 0x00.
- R10: RAM and SFR writes are ignored while `rst_n` is low and up to the second rising edge after it goes high. RAM contents survive a reset. `sfr_stb` and `sfr_we` stay low when `acc_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access valid this cycle |
| acc_we | input | 1 | Access is a write |
| acc_mode | input | 2 | 00 register, 01 direct, 10 indirect, 11 bit |
| bank_sel | input | 2 | Register bank from the status word |
| reg_sel | input | 3 | Register number in register mode |
| ptr_sel | input | 1 | Pointer register (0 or 1) in indirect mode |
| addr | input | 8 | Direct byte address or bit address |
| wdata | input | 8 | Byte write data |
| wbit | input | 1 | Bit write data |
| rdata | output | 8 | Selected byte |
| rbit | output | 1 | Selected bit in bit mode |
| rd_zero | output | 1 | Returned byte is zero |
| sfr_stb | output | 1 | SFR space selected |
| sfr_we | output | 1 | SFR write |
| sfr_addr | output | 8 | SFR byte address |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data |

## Verification
The hardest case to reach from the ports is the hidden upper RAM. Getting there takes two accesses before any check can be made. First, a pointer value above 0x7F is written into register 0 of a chosen bank. Then an indirect write through that pointer stores a known byte. After that, the stimulus sends a direct write to the same numeric address and checks that it is reported on the SFR side. A final indirect read must return the original byte, which shows that the direct write did not reach the RAM. Bit writes are set up the same way: the flag byte is loaded first, so that a merge into the wrong bit shows up when the byte is read back directly.

// File: rtl/iram_pkg.sv
package iram_pkg;
  typedef enum logic [1:0] {
    AM_REG = 2'b00,
    AM_DIR = 2'b01,
    AM_IND = 2'b10,
    AM_BIT = 2'b11
  } am_e;

  localparam logic [3:0] FLAG_BASE_HI = 4'h2;
endpackage

// File: rtl/iram_rst_gate.sv
module iram_rst_gate #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  logic [STAGES-1:0] q_r, q_nxt;

  always_comb begin
    q_nxt = {q_r[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign ready = q_r[STAGES-1];
endmodule

// File: rtl/iram_addr_path.sv
module iram_addr_path
  import iram_pkg::*;
#(
  parameter int AW = 8
) (
  input  am_e           mode,
  input  logic [1:0]    bank,
  input  logic [2:0]    reg_sel,
  input  logic          ptr_sel,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] ptr_val,
  output logic [AW-1:0] ptr_addr,
  output logic [AW-1:0] ram_addr,
  output logic [AW-1:0] sfr_addr,
  output logic          hit_sfr,
  output logic [2:0]    bit_idx
);
  localparam int PAD = AW - 5;

  always_comb begin
    ptr_addr = {{PAD{1'b0}}, bank, 2'b00, ptr_sel};
    ram_addr = '0;
    sfr_addr = '0;
    hit_sfr  = 1'b0;
    bit_idx  = addr[2:0];
    unique case (mode)
      AM_REG: ram_addr = {{PAD{1'b0}}, bank, reg_sel};
      AM_DIR: begin
        hit_sfr  = addr[AW-1];
        if (addr[AW-1]) sfr_addr = addr;
        else            ram_addr = addr;
      end
      AM_IND: ram_addr = ptr_val;
      AM_BIT: begin
        hit_sfr = addr[AW-1];
        if (addr[AW-1]) sfr_addr = {addr[AW-1:3], 3'b000};
        else            ram_addr = {{(AW-8){1'b0}}, FLAG_BASE_HI, addr[6:3]};
      end
      default: ram_addr = '0;
    endcase
  end
endmodule

// File: rtl/iram_store.sv
module iram_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_a_addr,
  output logic [DW-1:0] rd_a_data,
  input  logic [AW-1:0] rd_b_addr,
  output logic [DW-1:0] rd_b_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_a_data = mem[rd_a_addr];
  assign rd_b_data = mem[rd_b_addr];
endmodule

// File: rtl/iram_bank_decoder.sv
module iram_bank_decoder
  import iram_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_en,
  input  logic          acc_we,
  input  logic [1:0]    acc_mode,
  input  logic [1:0]    bank_sel,
  input  logic [2:0]    reg_sel,
  input  logic          ptr_sel,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wbit,
  output logic [DW-1:0] rdata,
  output logic          rbit,
  output logic          rd_zero,
  output logic          sfr_stb,
  output logic          sfr_we,
  output logic [AW-1:0] sfr_addr,
  output logic [DW-1:0] sfr_wdata,
  input  logic [DW-1:0] sfr_rdata
);
  am_e           mode;
  logic          wr_ok;
  logic [AW-1:0] ptr_addr, ram_addr;
  logic [DW-1:0] ptr_val, ram_byte, merged, wr_byte;
  logic          hit_sfr, ram_we;
  logic [2:0]    bit_idx;

  assign mode = am_e'(acc_mode);

  iram_rst_gate #(.STAGES(SYNC_STAGES)) u_gate (
    .clk(clk), .rst_n(rst_n), .ready(wr_ok)
  );

  iram_addr_path #(.AW(AW)) u_path (
    .mode(mode), .bank(bank_sel), .reg_sel(reg_sel), .ptr_sel(ptr_sel),
    .addr(addr), .ptr_val(ptr_val[AW-1:0]), .ptr_addr(ptr_addr),
    .ram_addr(ram_addr), .sfr_addr(sfr_addr), .hit_sfr(hit_sfr),
    .bit_idx(bit_idx)
  );

  iram_store #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .wr_en(ram_we), .wr_addr(ram_addr), .wr_data(wr_byte),
    .rd_a_addr(ptr_addr), .rd_a_data(ptr_val),
    .rd_b_addr(ram_addr), .rd_b_data(ram_byte)
  );

  always_comb begin
    rdata           = hit_sfr ? sfr_rdata : ram_byte;
    rbit            = rdata[bit_idx];
    merged          = rdata;
    merged[bit_idx] = wbit;
    wr_byte         = (mode == AM_BIT) ? merged : wdata;
    rd_zero         = (rdata == '0);
  end

  assign sfr_stb   = acc_en & hit_sfr;
  assign sfr_we    = sfr_stb & acc_we & wr_ok;
  assign sfr_wdata = wr_byte;
  assign ram_we    = acc_en & acc_we & wr_ok & ~hit_sfr;
endmodule

// File: rtl/iram_bank_decoder_chk.sv
module iram_bank_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_en,
  input logic       acc_we,
  input logic [1:0] acc_mode,
  input logic [1:0] bank_sel,
  input logic [2:0] reg_sel,
  input logic [7:0] addr,
  input logic [7:0] wdata,
  input logic       wbit,
  input logic [7:0] rdata,
  input logic       rbit,
  input logic       sfr_stb,
  input logic       sfr_we,
  input logic [7:0] sfr_rdata,
  input logic       wr_ok
);
  assert_direct_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_mode == 2'b01 && addr[7]) |-> (sfr_stb && rdata == sfr_rdata));

  assert_indirect_no_sfr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_mode == 2'b10) |-> !sfr_stb);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |-> (!sfr_stb && !sfr_we));

  assert_gate_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |-> !sfr_we);

  assert_reg_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc_en && acc_we && acc_mode == 2'b00 && wr_ok) &&
     acc_en && !acc_we && acc_mode == 2'b00 &&
     bank_sel == $past(bank_sel) && reg_sel == $past(reg_sel))
    |-> rdata == $past(wdata));

  assert_bit_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc_en && acc_we && acc_mode == 2'b11 && !addr[7] && wr_ok) &&
     acc_en && !acc_we && acc_mode == 2'b11 && addr == $past(addr))
    |-> rbit == $past(wbit));
endmodule

bind iram_bank_decoder iram_bank_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
  .acc_mode(acc_mode), .bank_sel(bank_sel), .reg_sel(reg_sel),
  .addr(addr), .wdata(wdata), .wbit(wbit), .rdata(rdata), .rbit(rbit),
  .sfr_stb(sfr_stb), .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .wr_ok(wr_ok)
);

// File: tb/sim_iram_bank_decoder.sv
`timescale 1ns/1ps
module sim_iram_bank_decoder;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       acc_en, acc_we, ptr_sel, wbit;
  logic [1:0] acc_mode, bank_sel;
  logic [2:0] reg_sel;
  logic [7:0] addr, wdata, sfr_rdata;
  logic [7:0] rdata, sfr_addr, sfr_wdata;
  logic       rbit, rd_zero, sfr_stb, sfr_we;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  iram_bank_decoder u0 (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
    .acc_mode(acc_mode), .bank_sel(bank_sel), .reg_sel(reg_sel),
    .ptr_sel(ptr_sel), .addr(addr), .wdata(wdata), .wbit(wbit),
    .rdata(rdata), .rbit(rbit), .rd_zero(rd_zero), .sfr_stb(sfr_stb),
    .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access: drive after the falling edge, sample 1 ns later (before rising edge)
  task automatic acc(logic [1:0] m, logic we, logic [1:0] bk, logic [2:0] rs,
                     logic ps, logic [7:0] a, logic [7:0] wd, logic wb);
    @(negedge clk);
    acc_en = 1'b1; acc_we = we; acc_mode = m; bank_sel = bk;
    reg_sel = rs; ptr_sel = ps; addr = a; wdata = wd; wbit = wb;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0;
    #1;
  endtask

  task automatic t_reset_state();
    check("R10 idle sfr_stb", {7'b0, sfr_stb}, 8'h00);
    check("R10 idle sfr_we",  {7'b0, sfr_we},  8'h00);
  endtask

  task automatic t_reg_map();
    acc(2'b00, 1'b1, 2'd2, 3'd5, 1'b0, 8'h00, 8'h3C, 1'b0);
    acc(2'b01, 1'b0, 2'd0, 3'd0, 1'b0, 8'h15, 8'h00, 1'b0);
    check("R1 bank2 r5 at 0x15", rdata, 8'h3C);
  endtask

  task automatic t_bank_switch();
    acc(2'b00, 1'b1, 2'd0, 3'd5, 1'b0, 8'h00, 8'h11, 1'b0);
    acc(2'b00, 1'b0, 2'd0, 3'd5, 1'b0, 8'h00, 8'h00, 1'b0);
    check("R2 bank0 r5", rdata, 8'h11);
    acc(2'b00, 1'b0, 2'd2, 3'd5, 1'b0, 8'h00, 8'h00, 1'b0);
    check("R2 bank2 r5 no delay", rdata, 8'h3C);
  endtask

  task automatic t_lower_shared();
    acc(2'b01, 1'b1, 2'd0, 3'd0, 1'b0, 8'h40, 8'h5A, 1'b0);
    acc(2'b00, 1'b1, 2'd0, 3'd0, 1'b0, 8'h00, 8'h40, 1'b0);
    acc(2'b00, 1'b1, 2'd0, 3'd1, 1'b0, 8'h00, 8'h41, 1'b0);
    acc(2'b10, 1'b0, 2'd0, 3'd0, 1'b0, 8'h00, 8'h00, 1'b0);
    check("R3 indirect sees direct write", rdata, 8'h5A);
    acc(2'b10, 1'b1, 2'd0, 3'd0, 1'b1, 8'h00, 8'h66, 1'b0);
    acc(2'b01, 1'b0, 2'd0, 3'd0, 1'b0, 8'h41, 8'h00, 1'b0);
    check("R3 direct sees indirect write", rdata, 8'h66);
  endtask

  task automatic t_upper_split();
    acc(2'b00, 1'b1, 2'd1, 3'd0, 1'b0, 8'h00, 8'h90, 1'b0);
    acc(2'b10, 1'b1, 2'd1, 3'd0, 1'b0, 8'h00, 8'hC3, 1'b0);
    check("R4 indirect upper no strobe", {7'b0, sfr_stb}, 8'h00);
    sfr_rdata = 8'h17;
    acc(2'b01, 1'b0, 2'd0, 3'd0, 1'b0, 8'h90, 8'h00, 1'b0);
    check("R5 direct upper strobe", {7'b0, sfr_stb}, 8'h01);
    check("R5 direct upper sfr_addr", sfr_addr, 8'h90);
    check("R5 direct upper rdata", rdata, 8'h17);
    acc(2'b01, 1'b1, 2'd0, 3'd0, 1'b0, 8'h90, 8'hEE, 1'b0);
    check("R5 sfr_we", {7'b0, sfr_we}, 8'h01);
    check("R5 sfr_wdata", sfr_wdata, 8'hEE);
    acc(2'b10, 1'b0, 2'd1, 3'd0, 1'b0, 8'h00, 8'h00, 1'b0);
    check("R4 hidden RAM kept after R5 write", rdata, 8'hC3);
  endtask

  task automatic t_pointer_sel();
    acc(2'b00, 1'b1, 2'd3, 3'd0, 1'b0, 8'h00, 8'h50, 1'b0);
    acc(2'b00, 1'b1, 2'd3, 3'd1, 1'b0, 8'h00, 8'h51, 1'b0);
    acc(2'b01, 1'b1, 2'd0, 3'd0, 1'b0, 8'h50, 8'hA1, 1'b0);
    acc(2'b01, 1'b1, 2'd0, 3'd0, 1'b0, 8'h51, 8'hB2, 1'b0);
    acc(2'b10, 1'b0, 2'd3, 3'd0, 1'b0, 8'h00, 8'h00, 1'b0);
    check("R6 pointer r0 bank3", rdata, 8'hA1);
    acc(2'b10, 1'b0, 2'd3, 3'd0, 1'b1, 8'h00, 8'h00, 1'b0);
    check("R6 pointer r1 bank3", rdata, 8'hB2);
  endtask

  task automatic t_bit_ram();
    acc(2'b01, 1'b1, 2'd0, 3'd0, 1'b0, 8'h2A, 8'h00, 1'b0);
    acc(2'b11, 1'b1, 2'd0, 3'd0, 1'b0, 8'h53, 8'h00, 1'b1);
    acc(2'b01, 1'b0, 2'd0, 3'd0, 1'b0, 8'h2A, 8'h00, 1'b0);
    check("R7 bit 0x53 sets byte 0x2A bit3", rdata, 8'h08);
    acc(2'b11, 1'b0, 2'd0, 3'd0, 1'b0, 8'h53, 8'h00, 1'b0);
    check("R7 rbit 0x53", {7'b0, rbit}, 8'h01);
    acc(2'b11, 1'b1, 2'd0, 3'd0, 1'b0, 8'h55, 8'h00, 1'b1);
    acc(2'b11, 1'b1, 2'd0, 3'd0, 1'b0, 8'h53, 8'h00, 1'b0);
    acc(2'b01, 1'b0, 2'd0, 3'd0, 1'b0, 8'h2A, 8'h00, 1'b0);
    check("R7 only target bit changes", rdata, 8'h20);
    acc(2'b01, 1'b1, 2'd0, 3'd0, 1'b0, 8'h2F, 8'h00, 1'b0);
    acc(2'b11, 1'b1, 2'd0, 3'd0, 1'b0, 8'h7F, 8'h00, 1'b1);
    acc(2'b01, 1'b0, 2'd0, 3'd0, 1'b0, 8'h2F, 8'h00, 1'b0);
    check("R7 top bit 0x7F", rdata, 8'h80);
  endtask

  task automatic t_bit_sfr();
    sfr_rdata = 8'h0F;
    acc(2'b11, 1'b1, 2'd0, 3'd0, 1'b0, 8'hE3, 8'h00, 1'b0);
    check("R8 sfr strobe", {7'b0, sfr_stb}, 8'h01);
    check("R8 sfr byte addr", sfr_addr, 8'hE0);
    check("R8 rbit from sfr", {7'b0, rbit}, 8'h01);
    check("R8 merged sfr_wdata", sfr_wdata, 8'h07);
  endtask

  task automatic t_zero();
    acc(2'b01, 1'b0, 2'd0, 3'd0, 1'b0, 8'h2F, 8'h00, 1'b0);
    check("R9 nonzero", {7'b0, rd_zero}, 8'h00);
    acc(2'b01, 1'b1, 2'd0, 3'd0, 1'b0, 8'h30, 8'h00, 1'b0);
    acc(2'b01, 1'b0, 2'd0, 3'd0, 1'b0, 8'h30, 8'h00, 1'b0);
    check("R9 zero", {7'b0, rd_zero}, 8'h01);
  endtask

  task automatic t_reset_gate();
    acc(2'b01, 1'b1, 2'd0, 3'd0, 1'b0, 8'h10, 8'h55, 1'b0);
    idle();
    rst_n = 1'b0;
    acc(2'b01, 1'b1, 2'd0, 3'd0, 1'b0, 8'h10, 8'hAA, 1'b0);
    acc(2'b01, 1'b1, 2'd0, 3'd0, 1'b0, 8'h10, 8'hAA, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    acc(2'b01, 1'b1, 2'd0, 3'd0, 1'b0, 8'h10, 8'hAB, 1'b0);
    acc(2'b01, 1'b0, 2'd0, 3'd0, 1'b0, 8'h10, 8'h00, 1'b0);
    check("R10 write gated, RAM kept", rdata, 8'h55);
    acc(2'b01, 1'b1, 2'd0, 3'd0, 1'b0, 8'h10, 8'h77, 1'b0);
    acc(2'b01, 1'b0, 2'd0, 3'd0, 1'b0, 8'h10, 8'h00, 1'b0);
    check("R10 write open after gate", rdata, 8'h77);
  endtask

  initial begin
    rst_n = 1'b0; acc_en = 1'b0; acc_we = 1'b0; acc_mode = 2'b00;
    bank_sel = 2'b00; reg_sel = 3'd0; ptr_sel = 1'b0; addr = 8'h00;
    wdata = 8'h00; wbit = 1'b0; sfr_rdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    t_reset_state();
    t_reg_map();
    t_bank_switch();
    t_lower_shared();
    t_upper_split();
    t_pointer_sel();
    t_bit_ram();
    t_bit_sfr();
    t_zero();
    t_reset_gate();
    idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule